// File: doc/BRIEF.md
# Memory Chip-Select Generator with Per-Select Wait States

This block watches a 20-bit memory address bus together with the memory-request, refresh and read/write strobes of a processor, and produces two active-low memory selects. The RAM select fires when the upper address byte falls inside a programmable inclusive window. The ROM select fires when the upper address byte is below a programmable boundary, and a control bit can switch the ROM select off entirely. Both compares work on address bits 19:12, so boundaries have 4 KB granularity.

Each select owns a wait-state generator. When a selected access begins, the shared active-low wait output is pulled low for the number of clock cycles programmed for that select (0 to 3) and then released, so slow memories can stretch the processor's access. Boundaries, wait counts and the ROM-off bit are loaded through a small synchronous register write port.

Top module: `memsel_gen`

## Requirements
- R1: The RAM select is low when addr[19:12] is greater than or equal to the lower window register and less than or equal to the upper window register (both ends included).
- R2: The ROM select is low when addr[19:12] is strictly less than the ROM boundary register.
- R3: When control bit 0 (ROM off) is 1, the ROM select stays high for every address.
- R4: When both compares match, the ROM select is low and the RAM select stays high.
- R5: Both selects stay high unless mreq_n is low and rfsh_n is high.
- R6: An access starts in the first cycle in which mreq_n is low, rfsh_n is high and rd_n or wr_n is low; from that cycle wait_n is low for exactly N cycles, N being the wait count of the active select: control bits 3:2 for RAM, bits 5:4 for ROM.
- R7: wait_n is high when no select is active, when N is 0, or once the access strobes go inactive, even if cycles of the count remain.
- R8: After reset the ROM boundary is 8'hFF, the lower window register 8'hFF, the upper window register 8'h00 (empty window), ROM off is 0 and both wait counts are 3.
- R9: A write with cfg_we high stores cfg_wdata at the next rising clock edge into register 0 (window lower), 1 (window upper), 2 (ROM boundary) or 3 (control).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register index for a write |
| cfg_wdata | input | 8 | Register write data |
| addr | input | 20 | Memory address bus |
| mreq_n | input | 1 | Memory request strobe, active low |
| rfsh_n | input | 1 | Refresh cycle indicator, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ram_sel_n | output | 1 | RAM select, active low |
| rom_sel_n | output | 1 | ROM select, active low |
| wait_n | output | 1 | Wait request, active low |

## Verification
The ROM and RAM decodes can both match the same address in the same cycle, and the wait output can be counting down in the same cycle that the strobes end. The first is provoked by opening the RAM window down to zero so it overlaps the ROM region, and judged by the ROM select being low with the RAM select high; turning ROM off then must hand that address to RAM. The second is provoked by ending a ROM access with three wait cycles after one cycle, and judged by wait_n being high as soon as the strobes rise.

// File: rtl/memsel_pkg.sv
// Package: shared widths, register indices, control-field positions and
// reset values for the memory chip-select generator.
package memsel_pkg;
    localparam int ADDR_W  = 20;
    localparam int BND_W   = 8;
    localparam int WAIT_W  = 2;
    localparam int CFG_AW  = 2;
    localparam int CTRL_W  = 8;

    // Register indices on the write port.
    localparam logic [CFG_AW-1:0] REG_WIN_LO = 2'd0;
    localparam logic [CFG_AW-1:0] REG_WIN_HI = 2'd1;
    localparam logic [CFG_AW-1:0] REG_ROM_BD = 2'd2;
    localparam logic [CFG_AW-1:0] REG_CTRL   = 2'd3;

    // Control-register field positions.
    localparam int CTRL_ROM_OFF  = 0;
    localparam int CTRL_RAM_WLSB = 2;
    localparam int CTRL_ROM_WLSB = 4;

    // Select channel indices.
    localparam int CH_RAM = 0;
    localparam int CH_ROM = 1;
    localparam int N_CH   = 2;
endpackage

// File: rtl/memsel_regs.sv
// Module: memsel_regs
// Holds the window, boundary and control registers, written through a
// single-cycle write port. Assumes cfg_addr selects one of four registers.
module memsel_regs
    import memsel_pkg::*;
#(
    parameter int BW = BND_W,
    parameter int WW = WAIT_W,
    parameter int CW = CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [BW-1:0]     cfg_wdata,
    output logic [BW-1:0]     win_lo,
    output logic [BW-1:0]     win_hi,
    output logic [BW-1:0]     rom_bd,
    output logic              rom_off,
    output logic [WW-1:0]     ram_wait,
    output logic [WW-1:0]     rom_wait
);
    localparam logic [CW-1:0] CTRL_RST =
        CW'(({WW{1'b1}} << CTRL_RAM_WLSB) | ({WW{1'b1}} << CTRL_ROM_WLSB));

    logic [CW-1:0] ctrl_q;

    // Register writes and reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_lo <= '1;
            win_hi <= '0;
            rom_bd <= '1;
            ctrl_q <= CTRL_RST;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_WIN_LO: win_lo <= cfg_wdata;
                REG_WIN_HI: win_hi <= cfg_wdata;
                REG_ROM_BD: rom_bd <= cfg_wdata;
                default:    ctrl_q <= CW'(cfg_wdata);
            endcase
        end
    end

    // Control-field extraction.
    always_comb begin
        rom_off  = ctrl_q[CTRL_ROM_OFF];
        ram_wait = ctrl_q[CTRL_RAM_WLSB +: WW];
        rom_wait = ctrl_q[CTRL_ROM_WLSB +: WW];
    end

    a_r9_bound_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == REG_ROM_BD) |=> (rom_bd == $past(cfg_wdata)));
endmodule

// File: rtl/memsel_decode.sv
// Module: memsel_decode
// Compares the upper address byte against the RAM window and ROM boundary
// and drives both active-low selects. ROM wins when both match. Assumes
// the bus strobes are already settled in the cycle being decoded.
module memsel_decode
    import memsel_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BND_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          mreq_n,
    input  logic          rfsh_n,
    input  logic [BW-1:0] win_lo,
    input  logic [BW-1:0] win_hi,
    input  logic [BW-1:0] rom_bd,
    input  logic          rom_off,
    output logic          ram_sel_n,
    output logic          rom_sel_n
);
    localparam int PAGE_LSB = AW - BW;

    logic [BW-1:0] page;
    logic          mem_cyc, ram_hit, rom_hit;

    // Range compares and priority resolution.
    always_comb begin
        page      = addr[AW-1:PAGE_LSB];
        mem_cyc   = !mreq_n && rfsh_n;
        rom_hit   = !rom_off && (page < rom_bd);
        ram_hit   = (page >= win_lo) && (page <= win_hi);
        rom_sel_n = !(mem_cyc && rom_hit);
        ram_sel_n = !(mem_cyc && ram_hit && !rom_hit);
    end

    a_r4_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!ram_sel_n, !rom_sel_n}));
endmodule

// File: rtl/memsel_wait.sv
// Module: memsel_wait
// Wait-state counter for one select. Holds wait_req for `count` cycles
// from the start cycle of an access; drops it when the access ends.
// Assumes start is only high in a cycle where active is also high.
module memsel_wait #(
    parameter int WW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          start,
    input  logic [WW-1:0] count,
    output logic          wait_req
);
    logic [WW-1:0] remain;

    // Remaining wait cycles after the start cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            remain <= '0;
        else if (start)
            remain <= (count == '0) ? '0 : count - WW'(1);
        else if (remain != '0)
            remain <= remain - WW'(1);
    end

    // Wait request: start cycle or remaining count.
    always_comb begin
        wait_req = active && ((start && count != '0) || remain != '0);
    end

    a_r7_idle_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !wait_req);
    a_r6_wait_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && !start) |-> $past(wait_req));
endmodule

// File: rtl/memsel_gen.sv
// Module: memsel_gen
// Top of the memory chip-select generator: registers, address decode and
// one wait-state counter per select, merged onto a single wait output.
// Assumes synchronous inputs and one access per strobe assertion.
module memsel_gen
    import memsel_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BND_W,
    parameter int WW = WAIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [BW-1:0]     cfg_wdata,
    input  logic [AW-1:0]     addr,
    input  logic              mreq_n,
    input  logic              rfsh_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              ram_sel_n,
    output logic              rom_sel_n,
    output logic              wait_n
);
    logic [BW-1:0]    win_lo, win_hi, rom_bd;
    logic             rom_off;
    logic [WW-1:0]    wcount [N_CH];
    logic [N_CH-1:0]  sel, wreq;
    logic             strobe, strobe_q;

    memsel_regs #(.BW(BW), .WW(WW), .CW(CTRL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .win_lo(win_lo), .win_hi(win_hi),
        .rom_bd(rom_bd), .rom_off(rom_off),
        .ram_wait(wcount[CH_RAM]), .rom_wait(wcount[CH_ROM])
    );

    memsel_decode #(.AW(AW), .BW(BW)) dec_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n),
        .rfsh_n(rfsh_n), .win_lo(win_lo), .win_hi(win_hi), .rom_bd(rom_bd),
        .rom_off(rom_off), .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n)
    );

    // Access strobe: memory request with a read or write, not refresh.
    always_comb begin
        strobe = !mreq_n && rfsh_n && (!rd_n || !wr_n);
        sel[CH_RAM] = !ram_sel_n;
        sel[CH_ROM] = !rom_sel_n;
    end

    // Previous-cycle strobe for start detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_wait
        memsel_wait #(.WW(WW)) wait_i (
            .clk(clk), .rst_n(rst_n),
            .active(strobe && sel[ch]),
            .start(strobe && !strobe_q && sel[ch]),
            .count(wcount[ch]),
            .wait_req(wreq[ch])
        );
    end

    // Merged active-low wait output.
    always_comb wait_n = !(|wreq);

    a_r5_idle_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_n || !rfsh_n) |-> (ram_sel_n && rom_sel_n));
    a_r3_rom_off: assert property (@(posedge clk) disable iff (!rst_n)
        rom_off |-> rom_sel_n);
endmodule

// File: tb/memsel_gen_tb.sv
// Directed bench for memsel_gen: one task per scenario.
module memsel_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [19:0] addr = '0;
    logic        mreq_n = 1'b1, rfsh_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        ram_sel_n, rom_sel_n, wait_n;
    int          n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    memsel_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .addr(addr), .mreq_n(mreq_n), .rfsh_n(rfsh_n),
        .rd_n(rd_n), .wr_n(wr_n), .ram_sel_n(ram_sel_n),
        .rom_sel_n(rom_sel_n), .wait_n(wait_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One access; checks selects in the first cycle and counts wait cycles.
    task automatic access(input string req, input logic [19:0] a, input logic is_wr,
                          input logic exp_ram, input logic exp_rom, input int exp_wait);
        int k;
        @(negedge clk);
        addr = a; mreq_n = 1'b0; rd_n = is_wr; wr_n = !is_wr;
        #1;
        chk({req, " ram_sel_n"}, ram_sel_n, !exp_ram);
        chk({req, " rom_sel_n"}, rom_sel_n, !exp_rom);
        k = 0;
        while (!wait_n && k < 8) begin
            k++;
            @(negedge clk); #1;
        end
        chk({req, " wait cycles"}, k, exp_wait);
        @(negedge clk);
        mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        #1;
        chk("R8 idle ram_sel_n", ram_sel_n, 1);
        chk("R8 idle rom_sel_n", rom_sel_n, 1);
        chk("R8 idle wait_n", wait_n, 1);
        access("R8 R2 R6 rom at 0", 20'h00000, 1'b0, 1'b0, 1'b1, 3);
        access("R8 R1 top page unselected", 20'hFF000, 1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_windows;
        wr_reg(2'd0, 8'h40);
        wr_reg(2'd1, 8'h7F);
        wr_reg(2'd2, 8'h10);
        wr_reg(2'd3, 8'h24);          // RAM wait 1, ROM wait 2, ROM on
        access("R1 R9 lower edge", 20'h40000, 1'b0, 1'b1, 1'b0, 1);
        access("R1 upper edge", 20'h7FFFF, 1'b1, 1'b1, 1'b0, 1);
        access("R1 below window", 20'h3FFFF, 1'b0, 1'b0, 1'b0, 0);
        access("R1 above window", 20'h80000, 1'b0, 1'b0, 1'b0, 0);
        access("R2 R6 last rom page", 20'h0FFFF, 1'b1, 1'b0, 1'b1, 2);
        access("R2 at boundary", 20'h10000, 1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_overlap;
        wr_reg(2'd0, 8'h00);
        access("R4 rom wins", 20'h05000, 1'b0, 1'b0, 1'b1, 2);
        wr_reg(2'd3, 8'h25);          // ROM off
        access("R3 rom off gives ram", 20'h05000, 1'b0, 1'b1, 1'b0, 1);
        wr_reg(2'd3, 8'h24);
    endtask

    task automatic t_strobes;
        @(negedge clk);
        addr = 20'h05000; mreq_n = 1'b0; rfsh_n = 1'b0; rd_n = 1'b0;
        #1;
        chk("R5 refresh rom_sel_n", rom_sel_n, 1);
        chk("R5 refresh ram_sel_n", ram_sel_n, 1);
        chk("R7 refresh wait_n", wait_n, 1);
        @(negedge clk);
        rfsh_n = 1'b1; mreq_n = 1'b1;
        #1;
        chk("R5 no mreq rom_sel_n", rom_sel_n, 1);
        @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_wait_edges;
        wr_reg(2'd3, 8'h30);          // RAM wait 0, ROM wait 3
        access("R7 zero wait", 20'h40000, 1'b0, 1'b1, 1'b0, 0);
        @(negedge clk);
        addr = 20'h01000; mreq_n = 1'b0; rd_n = 1'b0;
        #1;
        chk("R6 rom start wait_n", wait_n, 0);
        @(negedge clk);
        mreq_n = 1'b1; rd_n = 1'b1;
        #1;
        chk("R7 early end wait_n", wait_n, 1);
        @(negedge clk); #1;
        chk("R7 stays released", wait_n, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_windows();
                t_overlap();
                t_strobes();
                t_wait_edges();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule